// File: doc/BRIEF.md
# Implicit Vector Expansion Issuer

This block sits between instruction decode and the issue FIFO of a scalar core. It accepts one decoded register-register operation at a time: an opcode and three 5-bit register numbers for the destination and two sources. It looks each register up in a table of per-register vector lengths. The opcode itself is never changed. When a register has a length greater than one, the operation is expanded into a run of ordinary scalar micro-operations, one per element. Each vector-marked register number advances by the element index, and scalar operands are repeated unchanged.

A per-element mask for the destination can suppress individual elements, and a suppressed element produces no push. The FIFO side is a valid/ready push port. The block stalls while the FIFO is full. It takes the next decoded operation only after the current one has finished. Software fills the length table through a simple register write port.

Top module: `vexp_issuer`

## Requirements
- R1: After reset `inReady` is 1, `outValid` is 0, and every length table entry is 0.
- R2: A write with `cfgWe` high stores the 4-bit `cfgLen` as the length of register `cfgReg`. The new value applies to every operation accepted in a later cycle.
- R3: If no operand register has a length above 1, the operation produces exactly one push with opcode and register numbers unchanged, and `inPred` is ignored.
- R4: Lengths 0 and 1 both mark a register as scalar.
- R5: For a vector operation, the element count is the largest length among the operands whose length is above 1.
- R6: For element i, a vector-marked operand with register number N is issued as (N + i) mod 32. Elements leave in increasing order of i.
- R7: A scalar operand of a vector operation is issued with its own register number in every element.
- R8: For a vector operation, bit i of `inPred` (bit 0 is element 0) set to 0 skips element i without a push. A mask of all zeros gives no push, and the operation still completes after one cycle per element.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and the pushed fields hold. No element is lost or repeated.
- R10: `inReady` drops in the cycle after an accept. It rises again only after the last element has been pushed or skipped, and `outValid` is never 1 while `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Length table write strobe |
| cfgReg | input | 5 | Register whose length is written |
| cfgLen | input | 4 | Length value written |
| inValid | input | 1 | Decoded operation present |
| inReady | output | 1 | Block can accept an operation |
| inOp | input | 8 | Decoded opcode |
| inRd | input | 5 | Destination register number |
| inRs1 | input | 5 | First source register number |
| inRs2 | input | 5 | Second source register number |
| inPred | input | 15 | Destination element mask, bit i for element i |
| outValid | output | 1 | Micro-operation push request |
| outReady | input | 1 | FIFO has room |
| outOp | output | 8 | Pushed opcode |
| outRd | output | 5 | Pushed destination register |
| outRs1 | output | 5 | Pushed first source register |
| outRs2 | output | 5 | Pushed second source register |

## Verification
The assertions take for granted that a length write and an accept reading the same register never fall in the same cycle. They also take for granted that `outReady` is a plain level sampled only at the clock edge. The stimulus writes the table only between operations, and it changes `outReady` only a short delay after the rising edge.

Back-pressure is applied in several patterns: always ready, alternating, one cycle in three, and a long stall. These patterns are applied while vector runs are in flight, so the hold rule is exercised at element boundaries.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  // Strobes from the control FSM into the datapath.
  typedef struct packed {
    logic load;  // capture a new decoded operation
    logic step;  // current element resolved (pushed or skipped)
  } ctrlStrobe_t;
endpackage

// File: rtl/vexp_lentab.sv
module vexp_lentab #(
  parameter int NREG  = 32,
  parameter int LEN_W = 4,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [LEN_W-1:0] wrLen,
  input  logic [AW-1:0]    rdAddrA,
  input  logic [AW-1:0]    rdAddrB,
  input  logic [AW-1:0]    rdAddrC,
  output logic [LEN_W-1:0] rdLenA,
  output logic [LEN_W-1:0] rdLenB,
  output logic [LEN_W-1:0] rdLenC
);
  logic [LEN_W-1:0] lenTab [NREG];

  for (genvar g = 0; g < NREG; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            lenTab[g] <= '0;
      else if (wrEn && wrAddr == AW'(g))    lenTab[g] <= wrLen;
    end
  end

  assign rdLenA = lenTab[rdAddrA];
  assign rdLenB = lenTab[rdAddrB];
  assign rdLenC = lenTab[rdAddrC];
endmodule

// File: rtl/vexp_ctrl.sv
module vexp_ctrl
  import vexp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        elemLive,
  input  logic        lastElem,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  logic busyQ;

  assign inReady     = !busyQ;
  assign outValid    = busyQ && elemLive;
  assign strobe.load = inValid && !busyQ;
  assign strobe.step = busyQ && (!elemLive || outReady);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          busyQ <= 1'b0;
    else if (strobe.load)               busyQ <= 1'b1;
    else if (strobe.step && lastElem)   busyQ <= 1'b0;
  end

  // R10: an accept always leaves the block busy in the next cycle
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady);
endmodule

// File: rtl/vexp_dp.sv
module vexp_dp
  import vexp_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int AW    = 5,
  parameter int LEN_W = 4,
  localparam int PRED_W = (1 << LEN_W) - 1,
  localparam int NOPND  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [OP_W-1:0]   inOp,
  input  logic [AW-1:0]     inRd,
  input  logic [AW-1:0]     inRs1,
  input  logic [AW-1:0]     inRs2,
  input  logic [PRED_W-1:0] inPred,
  input  logic [LEN_W-1:0]  lenRd,
  input  logic [LEN_W-1:0]  lenRs1,
  input  logic [LEN_W-1:0]  lenRs2,
  output logic [OP_W-1:0]   outOp,
  output logic [AW-1:0]     outRd,
  output logic [AW-1:0]     outRs1,
  output logic [AW-1:0]     outRs2,
  output logic              elemLive,
  output logic              lastElem
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  function automatic logic [LEN_W-1:0] effLen(input logic [LEN_W-1:0] l);
    return (l > ONE) ? l : '0;
  endfunction

  logic [AW-1:0]    regIn [NOPND];
  logic [LEN_W-1:0] lenIn [NOPND];
  logic [AW-1:0]    regQ  [NOPND];
  logic [AW-1:0]    regOut[NOPND];
  logic [NOPND-1:0] vecQ;
  logic [LEN_W-1:0] maxD, countD, countQ, elemQ;
  logic [OP_W-1:0]  opQ;
  logic [PRED_W-1:0] predQ;
  logic             anyVecQ;

  assign regIn[0] = inRd;  assign regIn[1] = inRs1;  assign regIn[2] = inRs2;
  assign lenIn[0] = lenRd; assign lenIn[1] = lenRs1; assign lenIn[2] = lenRs2;

  always_comb begin
    maxD = '0;
    for (int k = 0; k < NOPND; k++)
      if (effLen(lenIn[k]) > maxD) maxD = effLen(lenIn[k]);
    countD = (maxD == '0) ? ONE : maxD;
  end

  for (genvar g = 0; g < NOPND; g++) begin : gOpnd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[g] <= '0;
        vecQ[g] <= 1'b0;
      end else if (strobe.load) begin
        regQ[g] <= regIn[g];
        vecQ[g] <= lenIn[g] > ONE;
      end
    end
    assign regOut[g] = regQ[g] + (vecQ[g] ? AW'(elemQ) : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ     <= '0;
      predQ   <= '0;
      countQ  <= ONE;
      anyVecQ <= 1'b0;
      elemQ   <= '0;
    end else if (strobe.load) begin
      opQ     <= inOp;
      predQ   <= inPred;
      countQ  <= countD;
      anyVecQ <= maxD != '0;
      elemQ   <= '0;
    end else if (strobe.step && !lastElem) begin
      elemQ   <= elemQ + ONE;
    end
  end

  assign outOp    = opQ;
  assign outRd    = regOut[0];
  assign outRs1   = regOut[1];
  assign outRs2   = regOut[2];
  assign elemLive = !anyVecQ || predQ[elemQ];
  assign lastElem = elemQ == countQ - ONE;

  // R5: the element index never runs past the element count
  assert_elem_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    elemQ < countQ);
  // R3: an operation without vector operands resolves as one live element
  assert_scalar_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && (maxD == '0) |=> lastElem && elemLive);
endmodule

// File: rtl/vexp_issuer.sv
module vexp_issuer
  import vexp_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int NREG  = 32,
  parameter int LEN_W = 4,
  localparam int AW     = $clog2(NREG),
  localparam int PRED_W = (1 << LEN_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [AW-1:0]     cfgReg,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              inValid,
  output logic              inReady,
  input  logic [OP_W-1:0]   inOp,
  input  logic [AW-1:0]     inRd,
  input  logic [AW-1:0]     inRs1,
  input  logic [AW-1:0]     inRs2,
  input  logic [PRED_W-1:0] inPred,
  output logic              outValid,
  input  logic              outReady,
  output logic [OP_W-1:0]   outOp,
  output logic [AW-1:0]     outRd,
  output logic [AW-1:0]     outRs1,
  output logic [AW-1:0]     outRs2
);
  ctrlStrobe_t      strobe;
  logic [LEN_W-1:0] lenRd, lenRs1, lenRs2;
  logic             elemLive, lastElem;

  vexp_lentab #(.NREG(NREG), .LEN_W(LEN_W)) u_lentab (
    .clk(clk), .rstN(rstN),
    .wrEn(cfgWe), .wrAddr(cfgReg), .wrLen(cfgLen),
    .rdAddrA(inRd), .rdAddrB(inRs1), .rdAddrC(inRs2),
    .rdLenA(lenRd), .rdLenB(lenRs1), .rdLenC(lenRs2)
  );

  vexp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .outReady(outReady),
    .elemLive(elemLive), .lastElem(lastElem),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  vexp_dp #(.OP_W(OP_W), .AW(AW), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inOp(inOp), .inRd(inRd), .inRs1(inRs1), .inRs2(inRs2), .inPred(inPred),
    .lenRd(lenRd), .lenRs1(lenRs1), .lenRs2(lenRs2),
    .outOp(outOp), .outRd(outRd), .outRs1(outRs1), .outRs2(outRs2),
    .elemLive(elemLive), .lastElem(lastElem)
  );

  // R9: a stalled push stays offered with unchanged fields
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable({outOp, outRd, outRs1, outRs2}));
  // R10: never pushing while idle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);
endmodule

// File: tb/vexp_issuer_bench.sv
module vexp_issuer_bench;
  localparam int OW = 8 + 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [4:0] cfgReg = '0;
  logic [3:0] cfgLen = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inOp = '0;
  logic [4:0] inRd = '0, inRs1 = '0, inRs2 = '0;
  logic [14:0] inPred = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [7:0] outOp;
  logic [4:0] outRd, outRs1, outRs2;

  always #4 clk = ~clk;  // 125 MHz

  vexp_issuer u_vexp_issuer (.*);

  int total = 0, bad = 0, cycles = 0, readyMode = 0, rdyCnt = 0;
  int lenM [32];
  logic [OW-1:0] expQ[$];
  string tagQ[$];
  logic heldValid = 1'b0;
  logic [OW-1:0] heldVec;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // back-pressure driver: changes only after the rising edge
  always @(posedge clk) begin
    #2;
    rdyCnt++;
    case (readyMode)
      0: outReady = 1'b1;
      1: outReady = ~outReady;
      2: outReady = (rdyCnt % 3 == 0);
      default: outReady = 1'b0;
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [OW-1:0] got;
    got = {outOp, outRd, outRs1, outRs2};
    if (rstN) begin
      if (heldValid) begin
        chk(outValid === 1'b1, "R9", "valid held", outValid, 1);
        chk(got === heldVec, "R9", "fields held", got, heldVec);
      end
      heldValid = outValid && !outReady;
      heldVec = got;
      if (outValid && outReady) begin
        if (expQ.size() == 0) chk(1'b0, "R8", "unexpected push", got, 0);
        else begin
          logic [OW-1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(got === e, t, "pushed micro-op", got, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<50000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic setLen(input int r, input int l);
    @(negedge clk);
    cfgWe = 1'b1; cfgReg = 5'(r); cfgLen = 4'(l);
    lenM[r] = l;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op, input int rd, input int rs1,
                       input int rs2, input logic [14:0] pred, input string tag);
    int mx;
    bit vd, v1, v2;
    vd = lenM[rd] > 1; v1 = lenM[rs1] > 1; v2 = lenM[rs2] > 1;
    mx = 0;
    if (vd && lenM[rd] > mx) mx = lenM[rd];
    if (v1 && lenM[rs1] > mx) mx = lenM[rs1];
    if (v2 && lenM[rs2] > mx) mx = lenM[rs2];
    if (mx == 0) begin
      expQ.push_back({op, 5'(rd), 5'(rs1), 5'(rs2)});
      tagQ.push_back(tag);
    end else begin
      for (int i = 0; i < mx; i++)
        if (pred[i]) begin
          expQ.push_back({op, 5'(rd + (vd ? i : 0)), 5'(rs1 + (v1 ? i : 0)),
                          5'(rs2 + (v2 ? i : 0))});
          tagQ.push_back(tag);
        end
    end
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inOp = op; inRd = 5'(rd); inRs1 = 5'(rs1); inRs2 = 5'(rs2);
    inPred = pred;
    @(negedge clk);
    inValid = 1'b0;
    chk(inReady === 1'b0, "R10", "busy after accept", inReady, 0);
  endtask

  task automatic drain();
    int n = 0;
    while ((expQ.size() != 0 || !inReady) && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(expQ.size() == 0, "R9", "all expected pushes seen", expQ.size(), 0);
  endtask

  initial begin
    for (int r = 0; r < 32; r++) lenM[r] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady === 1'b1, "R1", "inReady after reset", inReady, 1);
    chk(outValid === 1'b0, "R1", "outValid after reset", outValid, 0);

    // R1/R3: table is empty, operations pass through once, mask ignored
    issue(8'h11, 3, 9, 27, 15'h0, "R3");
    issue(8'h12, 31, 31, 0, 15'h7fff, "R1");
    drain();

    // R4: lengths 1 and 0 are both scalar
    setLen(4, 1); setLen(5, 0);
    issue(8'h21, 4, 5, 4, 15'h0, "R4");
    drain();

    // R6/R2: three-element vector add on r4..r6, r8.., r12..
    setLen(4, 3); setLen(8, 3); setLen(12, 3);
    issue(8'h31, 12, 4, 8, 15'h7fff, "R6");
    drain();

    // R7: scalar second source broadcast
    setLen(16, 4);
    issue(8'h41, 2, 16, 7, 15'h7fff, "R7");
    drain();

    // R5: count is the largest vector-marked length
    setLen(20, 2); setLen(21, 5); setLen(22, 3);
    issue(8'h51, 20, 21, 22, 15'h7fff, "R5");
    drain();

    // R6: register numbers wrap modulo 32
    setLen(30, 4);
    issue(8'h61, 1, 30, 3, 15'h7fff, "R6");
    drain();

    // R8: sparse mask
    issue(8'h71, 9, 16, 9, 15'h0005, "R8");
    drain();

    // R8/R10: all-skip run on three elements completes in three cycles
    issue(8'h72, 12, 4, 8, 15'h0000, "R8");
    @(negedge clk);
    @(negedge clk);
    chk(inReady === 1'b0, "R8", "still busy on last skipped element", inReady, 0);
    @(negedge clk);
    chk(inReady === 1'b1, "R10", "ready after last skip", inReady, 1);
    drain();

    // R9: back-pressure patterns over long runs
    setLen(0, 15);
    readyMode = 1;
    issue(8'h81, 0, 0, 5, 15'h7fff, "R9");
    issue(8'h82, 3, 30, 0, 15'h3a5c, "R9");
    drain();
    readyMode = 2;
    issue(8'h83, 0, 16, 0, 15'h7ffe, "R9");
    issue(8'h84, 14, 14, 14, 15'h0, "R9");
    drain();
    readyMode = 3;
    issue(8'h85, 20, 2, 2, 15'h0003, "R9");
    repeat (6) @(negedge clk);
    readyMode = 0;
    drain();

    // R2: rewriting a length changes later expansions
    setLen(16, 0);
    issue(8'h91, 2, 16, 7, 15'h7fff, "R2");
    setLen(7, 2);
    issue(8'h92, 2, 16, 7, 15'h7fff, "R2");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule